// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of one warp are allowed to commit results while the warp runs through nested divergent branches. All lanes execute both sides of every branch; the active mask produced here only gates the commit of each lane's result. Each branch carries a marker with a per-lane predicate. A push marker saves the current mask on a stack and narrows the mask to the active lanes whose predicate is true. A complement marker at the else point switches to the lanes of the saved parent mask that were not active. A pop marker at the reconvergence point restores the saved mask.

When the active mask becomes all zeros the block raises a skip indication, so the sequencer may bypass that path. The stack depth and lane count are parameters. Pushing onto a full stack, or complementing or popping with an empty stack, sets a sticky error flag and leaves the mask and the stack untouched.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset `mask_o` is all ones, `skip_o` is 0, and `ovf_o` and `unf_o` are 0.
- R2: The mask changes only on the clock edge that samples `valid_i` high with an operation; with `valid_i` low, or with `op_i` = 2'b00 (none), the mask and stack keep their values.
- R3: With `op_i` = 2'b01 (push) and a stack that is not full, the current mask is saved on the stack and the next mask is the current mask AND `pred_i`.
- R4: With `op_i` = 2'b10 (complement) and a non-empty stack, the next mask is the top stack entry AND NOT the current mask; the stack is not changed.
- R5: With `op_i` = 2'b11 (pop) and a non-empty stack, the next mask is the top stack entry and that entry is removed; nested pushes are restored in last-in, first-out order.
- R6: `skip_o` is 1 exactly when `mask_o` is all zeros.
- R7: A push while the stack holds DEPTH entries sets `ovf_o`, which stays 1 until reset; mask and stack are unchanged.
- R8: A complement or a pop while the stack is empty sets `unf_o`, which stays 1 until reset; mask and stack are unchanged.
- R9: Whenever the stack is empty the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Branch marker present this cycle |
| op_i | input | 2 | Marker: 00 none, 01 push, 10 complement, 11 pop |
| pred_i | input | LANES | Per-lane predicate, used by push |
| mask_o | output | LANES | Current active lane mask |
| skip_o | output | 1 | Active mask is all zeros |
| ovf_o | output | 1 | Sticky: push onto a full stack |
| unf_o | output | 1 | Sticky: complement or pop on an empty stack |

## Verification
On every cycle the assertions check that a push never activates a lane that was inactive, that a complement yields a mask disjoint from the previous one, that an idle cycle holds the mask, that the mask is all ones at zero depth, that skip only occurs inside a branch, and that overflow and underflow leave the mask unchanged while the flags never clear. The actual mask values after push, complement and pop, the last-in, first-out order of nested restores, and the exact depth at which overflow occurs are shown only by the bench's sweeps. The bench compares each step against a model of the stack in a small lane configuration.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_COMP = 2'b10,
    OP_POP  = 2'b11
  } mask_op_e;
endpackage

// File: rtl/simt_mask_ctrl.sv
module simt_mask_ctrl
  import simt_mask_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic            valid_i,
  input  mask_op_e        op_i,
  input  logic [SP_W-1:0] sp_i,
  output logic            push_o,
  output logic            pop_o,
  output logic            upd_o,
  output logic            ovf_evt_o,
  output logic            unf_evt_o
);
  logic full, empty, comp_ok;

  assign full  = (sp_i == SP_W'(DEPTH));
  assign empty = (sp_i == '0);

  always_comb begin
    push_o    = 1'b0;
    pop_o     = 1'b0;
    comp_ok   = 1'b0;
    ovf_evt_o = 1'b0;
    unf_evt_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_PUSH: if (full)  ovf_evt_o = 1'b1; else push_o  = 1'b1;
        OP_COMP: if (empty) unf_evt_o = 1'b1; else comp_ok = 1'b1;
        OP_POP:  if (empty) unf_evt_o = 1'b1; else pop_o   = 1'b1;
        default: ;
      endcase
    end
  end

  assign upd_o = push_o | pop_o | comp_ok;
endmodule

// File: rtl/simt_mask_store.sv
module simt_mask_store #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] wdata_i,
  output logic [LANES-1:0] top_o,
  output logic [SP_W-1:0]  sp_o
);
  logic [LANES-1:0] entry_q [DEPTH];
  logic [SP_W-1:0]  sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (push_i) sp_q <= sp_q + 1'b1;
    else if (pop_i)  sp_q <= sp_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            entry_q[i] <= '0;
      else if (push_i && sp_q == SP_W'(i))    entry_q[i] <= wdata_i;
    end
  end

  // top = entry at sp-1; zero when empty
  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top_o = entry_q[i];
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/simt_mask_next.sv
module simt_mask_next
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input  mask_op_e         op_i,
  input  logic [LANES-1:0] cur_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [LANES-1:0] top_i,
  output logic [LANES-1:0] next_o
);
  always_comb begin
    unique case (op_i)
      OP_PUSH: next_o = cur_i & pred_i;
      OP_COMP: next_o = top_i & ~cur_i;
      OP_POP:  next_o = top_i;
      default: next_o = cur_i;
    endcase
  end
endmodule

// File: rtl/simt_mask_err.sv
module simt_mask_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic unf_evt_i,
  output logic ovf_o,
  output logic unf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (ovf_evt_i) ovf_o <= 1'b1;
      if (unf_evt_i) unf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [LANES-1:0] pred_i,
  output logic [LANES-1:0] mask_o,
  output logic             skip_o,
  output logic             ovf_o,
  output logic             unf_o
);
  mask_op_e         op;
  logic [LANES-1:0] mask_q, mask_d, top;
  logic [SP_W-1:0]  sp;
  logic             push, pop, upd, ovf_evt, unf_evt;

  assign op = mask_op_e'(op_i);

  simt_mask_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .valid_i  (valid_i),
    .op_i     (op),
    .sp_i     (sp),
    .push_o   (push),
    .pop_o    (pop),
    .upd_o    (upd),
    .ovf_evt_o(ovf_evt),
    .unf_evt_o(unf_evt)
  );

  simt_mask_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .wdata_i(mask_q),
    .top_o  (top),
    .sp_o   (sp)
  );

  simt_mask_next #(.LANES(LANES)) u_next (
    .op_i  (op),
    .cur_i (mask_q),
    .pred_i(pred_i),
    .top_i (top),
    .next_o(mask_d)
  );

  simt_mask_err u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_evt_i(ovf_evt),
    .unf_evt_i(unf_evt),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mask_q <= '1;
    else if (upd) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign skip_o = ~|mask_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [LANES-1:0] mask_o,
  input logic             skip_o,
  input logic             ovf_o,
  input logic             unf_o
);
  logic [SP_W-1:0] d_q;
  logic            is_push, is_comp, is_pop;

  assign is_push = valid_i && op_i == 2'b01;
  assign is_comp = valid_i && op_i == 2'b10;
  assign is_pop  = valid_i && op_i == 2'b11;

  // independent depth tracker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                d_q <= '0;
    else if (is_push && d_q != SP_W'(DEPTH))    d_q <= d_q + 1'b1;
    else if (is_pop && d_q != '0)               d_q <= d_q - 1'b1;
  end

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mask_o));

  p_push_subset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_push && d_q != SP_W'(DEPTH) |=> (mask_o & ~$past(mask_o)) == '0);

  p_comp_disjoint_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_comp && d_q != '0 |=> (mask_o & $past(mask_o)) == '0);

  p_skip_nested_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> d_q != '0);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_push && d_q == SP_W'(DEPTH) |=> ovf_o && $stable(mask_o));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(ovf_o));

  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_comp || is_pop) && d_q == '0 |=> unf_o && $stable(mask_o));

  p_unf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(unf_o));

  p_root_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_q == '0 |-> &mask_o);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .mask_o (mask_o),
  .skip_o (skip_o),
  .ovf_o  (ovf_o),
  .unf_o  (unf_o)
);

// File: tb/simt_mask_stack_bench.sv
module simt_mask_stack_bench;
  localparam int LANES = 8;
  localparam int DEPTH = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid = 1'b0;
  logic [1:0]       op = 2'b00;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] mask;
  logic             skip, ovf, unf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk [DEPTH];
  int               m_sp;
  bit               m_ovf, m_unf;

  always #4 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_simt_mask_stack (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .pred_i(pred),
    .mask_o(mask), .skip_o(skip), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic compare(string tag);
    check({tag, " mask"}, 32'(mask), 32'(m_mask));
    check("R6 skip", 32'(skip), 32'(m_mask == '0));
    check("R7 ovf", 32'(ovf), 32'(m_ovf));
    check("R8 unf", 32'(unf), 32'(m_unf));
  endtask

  task automatic model(bit v, logic [1:0] o, logic [LANES-1:0] p);
    if (!v) return;
    case (o)
      2'b01: if (m_sp == DEPTH) m_ovf = 1'b1;
             else begin m_stk[m_sp] = m_mask; m_sp++; m_mask = m_mask & p; end
      2'b10: if (m_sp == 0) m_unf = 1'b1;
             else m_mask = m_stk[m_sp-1] & ~m_mask;
      2'b11: if (m_sp == 0) m_unf = 1'b1;
             else begin m_sp--; m_mask = m_stk[m_sp]; end
      default: ;
    endcase
  endtask

  task automatic apply(bit v, logic [1:0] o, logic [LANES-1:0] p);
    @(negedge clk);
    valid = v; op = o; pred = p;
    model(v, o, p);
    @(negedge clk);
    valid = 1'b0; op = 2'b00; pred = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    m_mask = '1; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    compare("R1 reset");

    // R2: idle and no-op markers hold state
    apply(1'b0, 2'b01, 8'h0F); compare("R2 valid low");
    apply(1'b1, 2'b00, 8'h0F); compare("R2 op none");

    // sweep every predicate from the root level
    for (int p = 0; p < 256; p++) begin
      apply(1'b1, 2'b01, 8'(p)); compare("R3 push");
      apply(1'b1, 2'b10, 8'h00); compare("R4 comp");
      apply(1'b1, 2'b11, 8'h00); compare("R5 pop");
      check("R9 root ones", 32'(mask), 32'hFF);
    end

    // sweep every predicate one level down
    apply(1'b1, 2'b01, 8'hA5); compare("R3 push outer");
    for (int p = 0; p < 256; p++) begin
      apply(1'b1, 2'b01, 8'(p)); compare("R3 push inner");
      apply(1'b1, 2'b10, 8'h00); compare("R4 comp inner");
      apply(1'b1, 2'b11, 8'h00); compare("R5 pop inner");
    end
    apply(1'b1, 2'b11, 8'h00); compare("R5 pop outer");

    // R5: LIFO order through full depth
    apply(1'b1, 2'b01, 8'hF0); apply(1'b1, 2'b01, 8'h30); apply(1'b1, 2'b01, 8'h10);
    compare("R5 nest3");
    apply(1'b1, 2'b11, 8'h00); check("R5 lifo 1", 32'(mask), 32'h30);
    apply(1'b1, 2'b11, 8'h00); check("R5 lifo 2", 32'(mask), 32'hF0);
    apply(1'b1, 2'b11, 8'h00); check("R5 lifo 3", 32'(mask), 32'hFF);

    // R7: overflow at DEPTH entries
    do_reset();
    for (int i = 0; i < DEPTH; i++) apply(1'b1, 2'b01, 8'hFE);
    check("R7 before ovf", 32'(ovf), 32'h0);
    apply(1'b1, 2'b01, 8'h00); compare("R7 overflow");
    check("R7 mask held", 32'(mask), 32'hFE);
    apply(1'b1, 2'b11, 8'h00); compare("R7 sticky after pop");

    // R8: underflow on pop and on complement
    do_reset();
    apply(1'b1, 2'b11, 8'h00); compare("R8 pop empty");
    check("R8 mask held", 32'(mask), 32'hFF);
    do_reset();
    apply(1'b1, 2'b10, 8'h00); compare("R8 comp empty");
    apply(1'b1, 2'b01, 8'h3C); compare("R8 sticky after push");

    // pseudo-random mixed sequences
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      if (n % 100 == 0) begin do_reset(); compare("R1 reset rand"); end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[0] | lfsr[1], lfsr[3:2], lfsr[15:8]);
      compare("R2 R3 R4 R5 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule